// File: doc/BRIEF.md
# Per-Channel Selectable Debounce Filter

A bank of digital input filters with one filter for each input channel. Every raw input passes through a two-flop synchronizer. A stability counter then runs while the synchronized level differs from the filtered level. The filtered output takes the new level only once that difference has lasted, without a break, for the whole duration the channel has selected. A shorter excursion resets the counter and never reaches the output.

Each channel picks one of four widely spaced durations: 4 us, 64 us, 1 ms or 8 ms. The choice is a 2-bit code held in a packed configuration register, and that register is written one 16-bit word at a time. The cycle counts for the durations are derived from the `CLK_FREQ_HZ` parameter. The filtered vector is the clean input state for readback, and it also feeds the downstream edge/event detection.

Top module: `chan_debounce_bank`

## Requirements
- R1: A raw input change that is held steady appears on `filt_o` at exactly the (TC+2)-th rising clock edge after it is applied: two edges for synchronization, then TC consecutive stable comparisons. Here TC is the terminal count of the channel's selected code.
- R2: An excursion of the raw input that lasts fewer than TC cycles is rejected. The counter restarts whenever the synchronized input equals the filtered output, and `filt_o` does not change.
- R3: Duration code 2'b00 selects 4 us, 2'b01 selects 64 us, 2'b10 selects 1 ms and 2'b11 selects 8 ms. TC is CLK_FREQ_HZ/250000, CLK_FREQ_HZ/15625, CLK_FREQ_HZ/1000 and CLK_FREQ_HZ/125 cycles respectively.
- R4: Each channel is filtered independently with its own code. Channel c's code sits at bits [2(c mod 8)+1 : 2(c mod 8)] of configuration word c/8.
- R5: When `cfg_we_i` is high at a rising edge, the word selected by `cfg_addr_i` takes `cfg_wdata_i`. The codes in the other words keep their values.
- R6: After reset, `filt_o` is all zeros, every counter is clear and every code is 2'b00 (4 us).
- R7: A code change takes effect at the next comparison. If a running counter has already reached the new, shorter terminal count, `filt_o` updates at the edge after the write edge.
- R8: Rising and falling transitions are filtered identically.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raw_i | input | N_CH | Unsynchronized raw inputs |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_addr_i | input | ADDR_W | Configuration word index (8 channels per word) |
| cfg_wdata_i | input | 16 | Packed 2-bit duration codes for the addressed word |
| filt_o | output | N_CH | Debounced input levels |

## Verification
A held input change is due on `filt_o` at the (TC+2)-th rising edge after it is applied. The bench drives stimulus on falling edges and counts falling edges from that point. It checks that the output is still unchanged after TC+1 edges and has changed after TC+2 edges, so both an early and a late update are caught. A rejected pulse of TC-1 cycles is checked several edges after its synchronized tail has passed. A code write takes effect at the comparison on the edge that follows the write edge, so the shortened-duration case is checked at the sample right after the write edge (output unchanged) and again one edge later (output changed).

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  typedef logic [1:0] dur_code_t;

  localparam dur_code_t DUR_4US  = 2'b00;
  localparam dur_code_t DUR_64US = 2'b01;
  localparam dur_code_t DUR_1MS  = 2'b10;
  localparam dur_code_t DUR_8MS  = 2'b11;

  function automatic int unsigned tc_cycles(input int unsigned clk_hz, input dur_code_t code);
    int unsigned n;
    case (code)
      DUR_4US:  n = clk_hz / 250000;
      DUR_64US: n = clk_hz / 15625;
      DUR_1MS:  n = clk_hz / 1000;
      default:  n = clk_hz / 125;
    endcase
    return (n == 0) ? 1 : n;
  endfunction
endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dbnc_cfg.sv
module dbnc_cfg #(
  parameter int unsigned N_CH   = 16,
  parameter int unsigned ADDR_W = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [15:0]         wdata_i,
  output logic [2*N_CH-1:0]   codes_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int unsigned WORD = c / 8;
    localparam int unsigned LSB  = 2 * (c % 8);
    logic [1:0] code_q;
    logic       hit;

    assign hit = we_i && (addr_i == ADDR_W'(WORD));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  code_q <= dbnc_pkg::DUR_4US;
      else if (hit) code_q <= wdata_i[LSB+:2];
    end

    assign codes_o[2*c+:2] = code_q;

    assert_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(WORD)) |=> (codes_o[2*c+:2] == $past(wdata_i[LSB+:2])));
    assert_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && addr_i == ADDR_W'(WORD)) |=> $stable(codes_o[2*c+:2]));
  end
endmodule

// File: rtl/dbnc_chan.sv
module dbnc_chan #(
  parameter int unsigned CLK_FREQ_HZ = 100_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_i,
  input  logic [1:0] code_i,
  output logic       filt_o
);
  import dbnc_pkg::*;

  localparam int unsigned TC0   = tc_cycles(CLK_FREQ_HZ, DUR_4US);
  localparam int unsigned TC1   = tc_cycles(CLK_FREQ_HZ, DUR_64US);
  localparam int unsigned TC2   = tc_cycles(CLK_FREQ_HZ, DUR_1MS);
  localparam int unsigned TC3   = tc_cycles(CLK_FREQ_HZ, DUR_8MS);
  localparam int unsigned CNT_W = $clog2(TC3 + 1);

  logic [CNT_W-1:0] cnt_q, last_q;
  logic             filt_q;

  // last count value before acceptance
  always_comb begin
    unique case (code_i)
      DUR_4US:  last_q = CNT_W'(TC0 - 1);
      DUR_64US: last_q = CNT_W'(TC1 - 1);
      DUR_1MS:  last_q = CNT_W'(TC2 - 1);
      default:  last_q = CNT_W'(TC3 - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (sync_i == filt_q) begin
      cnt_q  <= '0;
    end else if (cnt_q >= last_q) begin
      cnt_q  <= '0;
      filt_q <= sync_i;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign filt_o = filt_q;

  assert_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> ($past(sync_i) == filt_q));
  assert_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i == filt_q) |=> (cnt_q == '0));
  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(TC3));
endmodule

// File: rtl/chan_debounce_bank.sv
module chan_debounce_bank #(
  parameter  int unsigned N_CH        = 16,
  parameter  int unsigned CLK_FREQ_HZ = 100_000_000,
  localparam int unsigned N_WORDS     = (N_CH + 7) / 8,
  localparam int unsigned ADDR_W      = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   raw_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [15:0]       cfg_wdata_i,
  output logic [N_CH-1:0]   filt_o
);
  logic [N_CH-1:0]   sync_w;
  logic [2*N_CH-1:0] codes_w;

  dbnc_sync #(.W(N_CH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (sync_w)
  );

  dbnc_cfg #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .codes_o(codes_w)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_flt
    dbnc_chan #(.CLK_FREQ_HZ(CLK_FREQ_HZ)) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sync_i(sync_w[c]),
      .code_i(codes_w[2*c+:2]),
      .filt_o(filt_o[c])
    );
  end

  // R8: both edge directions follow the same path; output moves only toward the synchronized level
  assert_dir_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((filt_o ^ $past(filt_o)) & (filt_o ^ $past(sync_w))) == '0);
endmodule

// File: tb/sim_chan_debounce_bank.sv
module sim_chan_debounce_bank;
  localparam int unsigned N_CH = 16;
  localparam int unsigned CLK  = 1_000_000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N_CH-1:0] raw = '0;
  logic            we = 1'b0;
  logic [0:0]      addr = '0;
  logic [15:0]     wdata = '0;
  logic [N_CH-1:0] filt;
  logic [N_CH-1:0] exp_v = '0;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  chan_debounce_bank #(.N_CH(N_CH), .CLK_FREQ_HZ(CLK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .raw_i(raw), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .filt_o(filt)
  );

  function automatic int tc_of(input int code);
    case (code)
      0: return CLK / 250000;
      1: return CLK / 15625;
      2: return CLK / 1000;
      default: return CLK / 125;
    endcase
  endfunction

  task automatic check(input logic [N_CH-1:0] exp_x, input string tag);
    tests++;
    if (filt !== exp_x) begin
      fails++;
      $display("FAIL %s: filt_o=%h expected %h", tag, filt, exp_x);
    end
  endtask

  task automatic wr_word(input int w, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = 1'(w); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wr_code(input int ch, input int code);
    wr_word(ch / 8, 16'(code) << (2 * (ch % 8)));
  endtask

  // short pulse rejected, then held level accepted at edge tc+2
  task automatic run_edge(input int ch, input logic lvl, input int tc, input string tag);
    @(negedge clk);
    raw[ch] = lvl;
    repeat (tc - 1) @(negedge clk);
    raw[ch] = ~lvl;
    repeat (tc + 4) @(negedge clk);
    check(exp_v, {tag, " R2 pulse rejected"});
    raw[ch] = lvl;
    repeat (tc + 1) @(negedge clk);
    check(exp_v, {tag, " R1 not yet at edge tc+1"});
    @(negedge clk);
    exp_v[ch] = lvl;
    check(exp_v, {tag, " R1 accepted at edge tc+2"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check('0, "R6 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check('0, "R6 after release");

    // R6 default code is 4 us
    run_edge(3, 1'b1, tc_of(0), "R6 default 4us rise");

    // R3 R8 sweep codes across both words and both directions
    for (int code = 0; code < 4; code++) begin
      int ch = code * 5;
      wr_code(ch, code);
      run_edge(ch, 1'b1, tc_of(code), $sformatf("R3 code%0d ch%0d rise", code, ch));
      run_edge(ch, 1'b0, tc_of(code), $sformatf("R8 code%0d ch%0d fall", code, ch));
    end

    // R5 writing word 1 leaves word 0 codes intact
    wr_word(0, 16'h0001);
    wr_word(1, 16'hFFFF);
    run_edge(0, 1'b1, tc_of(1), "R5 word0 kept 64us");

    // R4 two channels with different codes, same stimulus
    wr_word(0, 16'h0010 | 16'h0001);
    @(negedge clk);
    raw[1] = 1'b1; raw[2] = 1'b1;
    repeat (5) @(negedge clk);
    check(exp_v, "R4 none yet");
    @(negedge clk);
    exp_v[1] = 1'b1;
    check(exp_v, "R4 ch1 4us only");
    repeat (59) @(negedge clk);
    check(exp_v, "R4 ch2 still pending");
    @(negedge clk);
    exp_v[2] = 1'b1;
    check(exp_v, "R4 ch2 64us");

    // R7 shorten duration mid-count
    wr_code(0, 3);
    @(negedge clk);
    raw[0] = 1'b0;
    repeat (100) @(negedge clk);
    check(exp_v, "R7 long count running");
    wr_code(0, 0);
    check(exp_v, "R7 unchanged at write edge");
    @(negedge clk);
    exp_v[0] = 1'b0;
    check(exp_v, "R7 update after write edge");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule